// File: doc/BRIEF.md
# Chained Descriptor Controller for One DMA Channel

This block runs the descriptor chain of a single DMA channel. It holds the channel's four descriptor words: the index word, the X count/modify word, the Y count/modify word and the control word. The address generator signals when the current descriptor has finished. If the control word asks for chaining, the block builds the address of the next descriptor from a compressed pointer and a memory-block select. It then reads the four words of that descriptor from consecutive memory words, loads them into the channel and starts the channel again.

Software loads a descriptor through a small register write port. A write to the control word starts an idle, done or failed channel. Two further register selects set and clear a pause flag. While the channel is paused, software may rewrite the descriptor. This lets a new chain be spliced in: copy the current pointer into the new chain's last descriptor, point the current descriptor at the new chain, then resume. The block reports idle, active, done or error, and it pulses an interrupt at the end of any descriptor that requests one.

Top module: `chain_dma_ctl`

## Requirements
- R1: After reset `status` is 0 (idle), `chan_run`, `paused`, `irq` and `mem_rd` are 0, and all four descriptor outputs are zero.
- R2: `status` encodes 0 idle, 1 active, 2 done, 3 error. A control-word write (select 3) made while the channel is idle, done or in error loads the word. The device type in bits 31:29 then decides the result: 000 gives idle, 011 or 111 gives error, and any other code gives active with `chan_run` high.
- R3: When `xfer_done` arrives while `chan_run` is high and chaining (bit 22) is clear, the next cycle shows done with `chan_run` low.
- R4: When `xfer_done` arrives while `chan_run` is high and bit 22 is set, the block reads four words, one per cycle, starting the cycle after `xfer_done`. The first address is block select (bits 16:15) times 2^17 plus pointer (bits 14:0) times 4. Each later address adds 4. Data is taken one cycle after each read, and the status stays active throughout.
- R5: The four fetched words replace index, X, Y and control in that order, on the cycle after each word's data arrives. The new control word's device type then selects active (the channel restarts), idle or error exactly as in R2.
- R6: If a chained descriptor ends with block select 3, status becomes error and no memory read is issued.
- R7: `irq` is high for exactly one cycle, the cycle after an accepted `xfer_done`, when bit 24 of the finishing control word is set. Otherwise it stays low.
- R8: A write to select 4 sets `paused` and a write to select 5 clears it. While paused, `chan_run` is low, `xfer_done` is ignored and the status stays active.
- R9: Descriptor writes (selects 0 to 3) are ignored while the channel runs unpaused and while a fetch is in progress.
- R10: While the channel is active and paused, descriptor writes are accepted without restarting it. After resume, the next chain step follows the rewritten pointer.
- R11: `dest_chan` always equals bits 21:17 of the current control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 index, 1 X, 2 Y, 3 control, 4 pause set, 5 pause clear |
| reg_wdata | input | 32 | Register write data |
| xfer_done | input | 1 | Current descriptor finished (from address generator) |
| mem_rd | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| status | output | 2 | 0 idle, 1 active, 2 done, 3 error |
| chan_run | output | 1 | Channel may move data |
| paused | output | 1 | Pause flag |
| irq | output | 1 | End-of-descriptor interrupt pulse |
| dest_chan | output | 5 | Destination channel field of the current control word |
| cur_index | output | 32 | Current index word |
| cur_xword | output | 32 | Current X count/modify word |
| cur_yword | output | 32 | Current Y count/modify word |
| cur_ctrl | output | 32 | Current control word |

## Verification
The assertions assume that `xfer_done` is raised only while `chan_run` is high, and that memory always returns data exactly one cycle after a read. They also assume that a pause write and `xfer_done` never fall in the same cycle. The stimulus keeps to these rules: it pulses `xfer_done` only after the model shows the channel running unpaused, it answers every read from a registered memory one cycle later, and it issues register writes one at a time between chain events. Deliberately ignored writes and ignored `xfer_done` pulses are still driven, so that their lack of effect is seen on the outputs.

// File: rtl/chdma_pkg.sv
package chdma_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;

    // status codes seen at the port
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DONE   = 2'd2,
        ST_ERROR  = 2'd3
    } stat_e;

    typedef enum logic [2:0] {
        F_IDLE, F_RUN, F_FETCH, F_DONE, F_ERR
    } fsm_e;

    // control word layout, msb first
    typedef struct packed {
        logic [2:0]  dev;       // 31:29
        logic        prio;      // 28
        logic        two_dim;   // 27
        logic [1:0]  opsize;    // 26:25
        logic        irq_en;    // 24
        logic        req_en;    // 23
        logic        chain_en;  // 22
        logic [4:0]  dest;      // 21:17
        logic [1:0]  blk;       // 16:15
        logic [14:0] ptr;       // 14:0
    } ctrl_t;

    localparam logic [2:0] SEL_INDEX = 3'd0;
    localparam logic [2:0] SEL_XW    = 3'd1;
    localparam logic [2:0] SEL_YW    = 3'd2;
    localparam logic [2:0] SEL_CTRL  = 3'd3;
    localparam logic [2:0] SEL_PSET  = 3'd4;
    localparam logic [2:0] SEL_PCLR  = 3'd5;

    function automatic logic dev_is_reserved(input logic [2:0] d);
        return (d == 3'b011) || (d == 3'b111);
    endfunction

    // state a channel enters once a control word takes effect
    function automatic fsm_e launch_state(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c = ctrl_t'(w);
        if (dev_is_reserved(c.dev)) return F_ERR;
        if (c.dev == 3'b000)        return F_IDLE;
        return F_RUN;
    endfunction

endpackage

// File: rtl/chdma_decode.sv
module chdma_decode
    import chdma_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output ctrl_t             fields,
    output logic              blk_bad
);
    always_comb begin
        fields  = ctrl_t'(word);
        blk_bad = (fields.blk == 2'd3);
    end
endmodule

// File: rtl/chdma_addr.sv
module chdma_addr #(
    parameter int AW      = 32,
    parameter int PTR_W   = 15,
    parameter int BLK_W   = 2,
    parameter int BLK_LSB = 17,
    parameter int IDX_W   = 3
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [BLK_W-1:0] blk,
    input  logic [IDX_W-1:0] widx,
    output logic [AW-1:0]    addr
);
    localparam int BYTE_SH = 2;

    logic [AW-1:0] blk_part, ptr_part, off_part;

    always_comb begin
        blk_part = AW'(blk)  << BLK_LSB;
        ptr_part = AW'(ptr)  << BYTE_SH;
        off_part = AW'(widx) << BYTE_SH;
        addr     = (blk_part | ptr_part) + off_part;
    end
endmodule

// File: rtl/chdma_pause.sv
module chdma_pause (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic paused
);
    always_ff @(posedge clk) begin
        if (rst)          paused <= 1'b0;
        else if (set_req) paused <= 1'b1;
        else if (clr_req) paused <= 1'b0;
    end

    // R8
    pause_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_req |=> paused);
    // R8
    pause_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_req) |=> !paused);
endmodule

// File: rtl/chain_dma_ctl.sv
module chain_dma_ctl
    import chdma_pkg::*;
#(
    parameter int AW      = 32,
    parameter int BLK_LSB = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic          xfer_done,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_rdata,
    output logic [1:0]    status,
    output logic          chan_run,
    output logic          paused,
    output logic          irq,
    output logic [4:0]    dest_chan,
    output logic [31:0]   cur_index,
    output logic [31:0]   cur_xword,
    output logic [31:0]   cur_yword,
    output logic [31:0]   cur_ctrl
);
    localparam int CNT_W = $clog2(DESC_WORDS + 1);

    fsm_e                  fsm_q;
    logic [WORD_W-1:0]     desc_q [DESC_WORDS];
    logic [CNT_W-1:0]      issue_cnt;
    logic                  data_pend;
    logic [CNT_W-1:0]      cap_w;
    ctrl_t                 cur;
    logic                  cur_blk_bad;
    logic                  desc_wr_ok, pset, pclr, done_ok;

    chdma_decode u_dec (
        .word    (desc_q[3]),
        .fields  (cur),
        .blk_bad (cur_blk_bad)
    );

    chdma_addr #(.AW(AW), .BLK_LSB(BLK_LSB), .IDX_W(CNT_W)) u_addr (
        .ptr  (cur.ptr),
        .blk  (cur.blk),
        .widx (issue_cnt),
        .addr (mem_addr)
    );

    assign pset = reg_we && (reg_sel == SEL_PSET);
    assign pclr = reg_we && (reg_sel == SEL_PCLR);

    chdma_pause u_pause (
        .clk     (clk),
        .rst     (rst),
        .set_req (pset),
        .clr_req (pclr),
        .paused  (paused)
    );

    always_comb begin
        chan_run   = (fsm_q == F_RUN) && !paused;
        done_ok    = chan_run && xfer_done;
        desc_wr_ok = reg_we && (reg_sel <= SEL_CTRL) &&
                     (fsm_q != F_FETCH) && !chan_run;
        mem_rd     = (fsm_q == F_FETCH) && (issue_cnt < CNT_W'(DESC_WORDS));
        cap_w      = issue_cnt - CNT_W'(1);
        unique case (fsm_q)
            F_DONE:  status = ST_DONE;
            F_ERR:   status = ST_ERROR;
            F_IDLE:  status = ST_IDLE;
            default: status = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q     <= F_IDLE;
            issue_cnt <= '0;
            data_pend <= 1'b0;
            irq       <= 1'b0;
            for (int i = 0; i < DESC_WORDS; i++) desc_q[i] <= '0;
        end else begin
            irq <= 1'b0;
            if (fsm_q == F_FETCH) begin
                if (mem_rd) issue_cnt <= issue_cnt + CNT_W'(1);
                data_pend <= mem_rd;
                if (data_pend) begin
                    desc_q[cap_w[1:0]] <= mem_rdata;
                    if (cap_w == CNT_W'(DESC_WORDS - 1))
                        fsm_q <= launch_state(mem_rdata);
                end
            end else if (done_ok) begin
                irq <= cur.irq_en;
                if (!cur.chain_en)   fsm_q <= F_DONE;
                else if (cur_blk_bad) fsm_q <= F_ERR;
                else begin
                    fsm_q     <= F_FETCH;
                    issue_cnt <= '0;
                    data_pend <= 1'b0;
                end
            end else if (desc_wr_ok) begin
                desc_q[reg_sel[1:0]] <= reg_wdata;
                if (reg_sel == SEL_CTRL && fsm_q != F_RUN)
                    fsm_q <= launch_state(reg_wdata);
            end
        end
    end

    assign cur_index = desc_q[0];
    assign cur_xword = desc_q[1];
    assign cur_yword = desc_q[2];
    assign cur_ctrl  = desc_q[3];
    assign dest_chan = cur.dest;

    // R4
    fetch_consecutive_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(4)));
    // R6
    no_read_on_error_chk: assert property (@(posedge clk) disable iff (rst)
        (status == ST_ERROR) |-> !mem_rd);
    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    // R3
    plain_done_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_run && xfer_done && !cur.chain_en) |=> (status == ST_DONE && !chan_run));
    // R8
    paused_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (paused && fsm_q == F_RUN && !pclr) |=> (status == ST_ACTIVE && !chan_run));
endmodule

// File: tb/chain_dma_ctl_test.sv
`timescale 1ns/1ps
module chain_dma_ctl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        xfer_done = 1'b0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  status;
    logic        chan_run, paused, irq;
    logic [4:0]  dest_chan;
    logic [31:0] cur_index, cur_xword, cur_yword, cur_ctrl;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    chain_dma_ctl uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .xfer_done(xfer_done), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .status(status),
        .chan_run(chan_run), .paused(paused), .irq(irq), .dest_chan(dest_chan),
        .cur_index(cur_index), .cur_xword(cur_xword), .cur_yword(cur_yword),
        .cur_ctrl(cur_ctrl)
    );

    // descriptor memory, one cycle read latency
    logic [31:0] mem [logic [31:0]];
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return ~a;
    endfunction
    always @(posedge clk) mem_rdata <= mem_word(mem_addr);

    // behavioural reference: 0 idle,1 run,2 fetch,3 done,4 error
    int          m_st = 0;
    int          m_fc = 0;
    bit          m_pause = 0;
    bit          m_irq = 0;
    logic [31:0] m_d [4];
    logic [31:0] m_base = 0;

    function automatic int start_of(input logic [31:0] w);
        if (w[31:29] == 3'b011 || w[31:29] == 3'b111) return 4;
        if (w[31:29] == 3'b000) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_fc = 0; m_pause = 0; m_irq = 0;
            for (int i = 0; i < 4; i++) m_d[i] = '0;
        end else begin
            automatic bit run_now = (m_st == 1) && !m_pause;
            m_irq = 0;
            if (m_st == 2) begin
                m_fc++;
                if (m_fc >= 2) begin
                    m_d[m_fc-2] = mem_word(m_base + 32'(4 * (m_fc - 2)));
                    if (m_fc == 5) m_st = start_of(m_d[3]);
                end
            end else if (run_now && xfer_done) begin
                m_irq = m_d[3][24];
                if (!m_d[3][22]) m_st = 3;
                else if (m_d[3][16:15] == 2'd3) m_st = 4;
                else begin
                    m_st = 2; m_fc = 0;
                    m_base = 32'(m_d[3][16:15]) * 32'h20000 + 32'(m_d[3][14:0]) * 4;
                end
            end else if (reg_we && reg_sel <= 3 && !run_now) begin
                m_d[reg_sel] = reg_wdata;
                if (reg_sel == 3 && m_st != 1) m_st = start_of(reg_wdata);
            end
            if (reg_we && reg_sel == 4) m_pause = 1;
            else if (reg_we && reg_sel == 5) m_pause = 0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [1:0] m_status();
        case (m_st)
            0: return 2'd0;
            3: return 2'd2;
            4: return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

    // compare every cycle, away from the active edge
    always @(negedge clk) if (!rst) begin
        automatic bit exp_rd = (m_st == 2) && (m_fc < 4);
        check("R2 status", 32'(status), 32'(m_status()));
        check("R8 chan_run", 32'(chan_run), 32'((m_st == 1) && !m_pause));
        check("R8 paused", 32'(paused), 32'(m_pause));
        check("R7 irq", 32'(irq), 32'(m_irq));
        check("R6 mem_rd", 32'(mem_rd), 32'(exp_rd));
        if (exp_rd) check("R4 mem_addr", mem_addr, m_base + 32'(4 * m_fc));
        check("R5 index", cur_index, m_d[0]);
        check("R5 xword", cur_xword, m_d[1]);
        check("R5 yword", cur_yword, m_d[2]);
        check("R5 ctrl", cur_ctrl, m_d[3]);
        check("R11 dest", 32'(dest_chan), 32'(m_d[3][21:17]));
    end

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask
    task automatic done_pulse();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // control word builder: dev, irq, chain, dest, blk, ptr
    function automatic logic [31:0] cw(input logic [2:0] dv, input bit ie, input bit ch,
                                       input logic [4:0] ds, input logic [1:0] bk,
                                       input logic [14:0] pt);
        return {dv, 1'b0, 1'b0, 2'b01, ie, 1'b0, ch, ds, bk, pt};
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] i0,
                            input logic [31:0] x0, input logic [31:0] y0,
                            input logic [31:0] c0);
        mem[a] = i0; mem[a+4] = x0; mem[a+8] = y0; mem[a+12] = c0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // chain A at block 1 ptr 0x10, B at block 2 ptr 0x200, C at block 0 ptr 0x40
        put_desc(32'h0002_0040, 32'hA000_0000, 32'h0010_0004, 32'h0, cw(3'b010, 1, 1, 5'd7, 2'd2, 15'h200));
        put_desc(32'h0004_0800, 32'hB000_0000, 32'h0008_0001, 32'h1, cw(3'b001, 0, 0, 5'd9, 2'd0, 15'h0));
        put_desc(32'h0000_0100, 32'hC000_0000, 32'h0004_0002, 32'h2, cw(3'b101, 1, 0, 5'd3, 2'd0, 15'h0));
        put_desc(32'h0000_0200, 32'hD000_0000, 32'h0, 32'h0, cw(3'b111, 0, 0, 5'd1, 2'd0, 15'h0));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 status", 32'(status), 32'd0);
        check("R1 run", 32'(chan_run), 32'd0);
        check("R1 ctrl", cur_ctrl, 32'd0);

        // R2 start, R3 plain finish, R7 interrupt
        wr(3'd0, 32'h1234_0000);
        wr(3'd1, 32'h0010_0004);
        wr(3'd3, cw(3'b100, 1, 0, 5'd5, 2'd0, 15'h0));
        idle(2);
        done_pulse();
        idle(2);
        // R2 reserved type and disable
        wr(3'd3, cw(3'b011, 0, 0, 5'd0, 2'd0, 15'h0));
        idle(1);
        wr(3'd3, cw(3'b000, 0, 0, 5'd0, 2'd0, 15'h0));
        idle(1);

        // R4 R5 two-step chain, R9 writes while running and fetching
        wr(3'd3, cw(3'b100, 0, 1, 5'd2, 2'd1, 15'h10));
        wr(3'd0, 32'hFFFF_FFFF);            // R9 ignored: running
        done_pulse();
        wr(3'd1, 32'hEEEE_EEEE);            // R9 ignored: fetching
        idle(6);
        done_pulse();
        idle(7);
        done_pulse();
        idle(2);

        // R8 pause, ignored done, R10 insertion of chain C
        wr(3'd3, cw(3'b100, 0, 1, 5'd4, 2'd1, 15'h10));
        wr(3'd4, 32'h0);
        done_pulse();                        // R8 ignored while paused
        idle(2);
        wr(3'd3, cw(3'b100, 0, 1, 5'd4, 2'd0, 15'h40));  // R10 splice
        wr(3'd5, 32'h0);
        done_pulse();
        idle(7);
        done_pulse();
        idle(2);

        // R6 block select 3
        wr(3'd3, cw(3'b100, 1, 1, 5'd0, 2'd3, 15'h1));
        done_pulse();
        idle(3);
        // R5 fetched descriptor with reserved type ends in error
        wr(3'd3, cw(3'b100, 0, 1, 5'd0, 2'd0, 15'h80));
        done_pulse();
        idle(8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule